// File: doc/BRIEF.md
# Buffered Program Command Interface

This block models the device side of a flash part's buffered-program command path. An external master drives bus cycles through an active-low chip enable, write enable and output enable, a word address and a 16-bit data bus. Software opens a sequence by writing the setup code to an address in a block. The next cycle supplies a word count, and then that many data words arrive for the block. A confirm code closes the sequence. The block collects the data words in a 256-word staging buffer while it checks that every address stays inside the block named at setup. It then spends a timed busy period moving the buffer into a small behavioural array.

The address is split into a block number in the upper bits and a word offset in the lower `BUF_AW` bits. A block is exactly as large as the staging buffer, so the offset of a data write is also its buffer slot. Reads return either array contents or the status word, according to the mode. The read data is latched only when a new read strobe starts.

Top module: `wbuf_cmd_if`

## Requirements
- R1: After reset the array reads all ones (FFFFh) in read-array mode, and the status word reads 0080h (ready, no error flags) once status mode is selected with a 70h write.
- R2: A write of E8h in read-array or status mode records the block number `addr[ADDR_W-1:BUF_AW]`, opens the count step and switches reads to the status word, which reads 0080h at that point.
- R3: The write that follows setup is always taken as the count. `wdata[7:0]` holds N-1, covering 00h to FFh, and a value of 70h gives 113 words rather than acting as a command.
- R4: Each data write stores `wdata` in buffer slot `addr[BUF_AW-1:0]`, and a later write to the same slot replaces the earlier one. After N data writes, the following write is treated as the confirm.
- R5: A data or confirm write whose block number differs from the one recorded at setup aborts the sequence. It sets status bits 5 and 4 (reading 00B0h), leaves the array unchanged and stays in status mode.
- R6: A confirm write whose `wdata[7:0]` is not D0h aborts in the same way as R5 (00B0h, array unchanged).
- R7: A D0h confirm to the recorded block starts programming. Status bit 7 reads 0 (0000h) for the busy period of `2**BUF_AW + PROG_WAIT` cycles and then returns to 1 (0080h).
- R8: Programming only clears bits: each written slot's array word becomes the old word ANDed with the buffered word. Slots not written in the sequence keep their array value.
- R9: While busy, every write is ignored. An FFh written during busy leaves the block in status mode after completion.
- R10: `rdata` changes only on the first cycle of a read strobe (chip enable and output enable low, write enable high) and holds while that strobe stays asserted, even if the status changes underneath.
- R11: A 50h write clears status bits 5 and 4 and leaves the mode as it was. An FFh write returns reads to array contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all bus pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable; a write is taken on the first cycle it is low with `ce_n` |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Word address: block number above, buffer offset in the low `BUF_AW` bits |
| wdata | input | DATA_W | Write data, command code in the low byte |
| rdata | output | DATA_W | Registered read data, either array word or status word |

## Verification
The checker assumes that write enable and output enable are never low together. It also assumes that the bus pins are held steady for at least one clock around each strobe edge, so that one strobe produces exactly one write event or one read event. The bench drives every pin at the falling clock edge and always opens a strobe, holds it for two cycles and then closes it for one. It never asserts both enables at once. Random block numbers, counts, offsets and data therefore stay inside those assumptions.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    typedef enum logic [2:0] {
        ST_ARRAY,
        ST_STATUS,
        ST_COUNT,
        ST_DATA,
        ST_CONFIRM,
        ST_PROG,
        ST_WAIT
    } wb_state_e;

    localparam logic [7:0] OP_SETUP   = 8'hE8;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;
    localparam logic [7:0] OP_CLEAR   = 8'h50;
    localparam logic [7:0] OP_ARRAY   = 8'hFF;
    localparam logic [7:0] OP_STATUS  = 8'h70;

    localparam int SR_READY = 7;
    localparam int SR_SEQ   = 5;
    localparam int SR_PGM   = 4;

endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ridx,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    slot_q [DEPTH];
    logic [DEPTH-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (we) slot_q[widx] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   valid_q <= '0;
        else if (clr) valid_q <= '0;
        else if (we)  valid_q[widx] <= 1'b1;
    end

    assign rdata  = slot_q[ridx];
    assign rvalid = valid_q[ridx];
endmodule

// File: rtl/wbuf_array.sv
module wbuf_array #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          pg_en,
    input  logic [AW-1:0] pg_addr,
    input  logic [DW-1:0] pg_data
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] cell_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) cell_q[i] <= '1;
        end else if (pg_en) begin
            cell_q[pg_addr] <= cell_q[pg_addr] & pg_data;
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/wbuf_cmd_if.sv
module wbuf_cmd_if
    import wbuf_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int BUF_AW    = 8,
    parameter int DATA_W    = 16,
    parameter int PROG_WAIT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int BLK_W  = ADDR_W - BUF_AW;
    localparam int DEPTH  = 1 << BUF_AW;
    localparam int WAIT_W = $clog2(PROG_WAIT + 1);

    typedef struct packed {
        wb_state_e         state;
        logic [BLK_W-1:0]  blk;
        logic [BUF_AW-1:0] cnt;
        logic [BUF_AW-1:0] walk;
        logic [WAIT_W-1:0] wait_cnt;
        logic              seq_err;
        logic              pgm_err;
        logic              wr_act;
        logic              rd_act;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t q, d;

    logic              wr_now, rd_now, wr_evt, rd_evt, busy;
    logic [7:0]        cmd;
    logic [BLK_W-1:0]  addr_blk;
    logic [BUF_AW-1:0] addr_off;
    logic [DATA_W-1:0] sr, arr_rdata, buf_rdata;
    logic              buf_we, buf_clr, buf_valid, pg_en;

    assign wr_now   = !ce_n && !we_n;
    assign rd_now   = !ce_n && !oe_n && we_n;
    assign wr_evt   = wr_now && !q.wr_act;
    assign rd_evt   = rd_now && !q.rd_act;
    assign busy     = (q.state == ST_PROG) || (q.state == ST_WAIT);
    assign cmd      = wdata[7:0];
    assign addr_blk = addr[ADDR_W-1:BUF_AW];
    assign addr_off = addr[BUF_AW-1:0];

    always_comb begin
        sr           = '0;
        sr[SR_READY] = !busy;
        sr[SR_SEQ]   = q.seq_err;
        sr[SR_PGM]   = q.pgm_err;
    end

    always_comb begin
        d        = q;
        d.wr_act = wr_now;
        d.rd_act = rd_now;
        buf_we   = 1'b0;
        buf_clr  = 1'b0;
        pg_en    = 1'b0;

        if (rd_evt) d.rdata = (q.state == ST_ARRAY) ? arr_rdata : sr;

        unique case (q.state)
            ST_ARRAY, ST_STATUS: begin
                if (wr_evt) begin
                    unique case (cmd)
                        OP_SETUP: begin
                            d.state = ST_COUNT;
                            d.blk   = addr_blk;
                            buf_clr = 1'b1;
                        end
                        OP_CLEAR: begin
                            d.seq_err = 1'b0;
                            d.pgm_err = 1'b0;
                        end
                        OP_ARRAY:  d.state = ST_ARRAY;
                        OP_STATUS: d.state = ST_STATUS;
                        default: ;
                    endcase
                end
            end
            ST_COUNT: begin
                if (wr_evt) begin
                    d.cnt   = wdata[BUF_AW-1:0];
                    d.state = ST_DATA;
                end
            end
            ST_DATA: begin
                if (wr_evt) begin
                    if (addr_blk != q.blk) begin
                        d.state   = ST_STATUS;
                        d.seq_err = 1'b1;
                        d.pgm_err = 1'b1;
                    end else begin
                        buf_we = 1'b1;
                        if (q.cnt == '0) d.state = ST_CONFIRM;
                        else             d.cnt   = q.cnt - BUF_AW'(1);
                    end
                end
            end
            ST_CONFIRM: begin
                if (wr_evt) begin
                    if (addr_blk == q.blk && cmd == OP_CONFIRM) begin
                        d.state = ST_PROG;
                        d.walk  = '0;
                    end else begin
                        d.state   = ST_STATUS;
                        d.seq_err = 1'b1;
                        d.pgm_err = 1'b1;
                    end
                end
            end
            ST_PROG: begin
                pg_en  = buf_valid;
                d.walk = q.walk + BUF_AW'(1);
                if (q.walk == BUF_AW'(DEPTH - 1)) begin
                    d.state    = ST_WAIT;
                    d.wait_cnt = WAIT_W'(PROG_WAIT - 1);
                end
            end
            ST_WAIT: begin
                if (q.wait_cnt == '0) d.state = ST_STATUS;
                else                  d.wait_cnt = q.wait_cnt - WAIT_W'(1);
            end
            default: d.state = ST_STATUS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_ARRAY;
        end else begin
            q <= d;
        end
    end

    assign rdata = q.rdata;

    wbuf_store #(.AW(BUF_AW), .DW(DATA_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (buf_clr),
        .we     (buf_we),
        .widx   (addr_off),
        .wdata  (wdata),
        .ridx   (q.walk),
        .rdata  (buf_rdata),
        .rvalid (buf_valid)
    );

    wbuf_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr   (addr),
        .rdata   (arr_rdata),
        .pg_en   (pg_en),
        .pg_addr ({q.blk, q.walk}),
        .pg_data (buf_rdata)
    );

    wb_state_e state_q;
    logic      seq_err_q, pgm_err_q;
    assign state_q   = q.state;
    assign seq_err_q = q.seq_err;
    assign pgm_err_q = q.pgm_err;
endmodule

// File: rtl/wbuf_cmd_if_chk.sv
module wbuf_cmd_if_chk
    import wbuf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [7:0]        cmd,
    input logic [DATA_W-1:0] rdata,
    input wb_state_e         state,
    input logic              seq_err,
    input logic              pgm_err,
    input logic              buf_we,
    input logic              pg_en
);
    logic rd_on, wr_on, busy;
    assign rd_on = !ce_n && !oe_n && we_n;
    assign wr_on = !ce_n && !we_n;
    assign busy  = (state == ST_PROG) || (state == ST_WAIT);

    AST_SETUP_OPENS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ARRAY || state == ST_STATUS) && wr_on && !$past(wr_on) && cmd == OP_SETUP) |=> (state == ST_COUNT)); // R2
    AST_COUNT_ANY_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && wr_on && !$past(wr_on)) |=> (state == ST_DATA)); // R3
    AST_ERR_FLAGS_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err == pgm_err); // R5
    AST_PROG_ONLY_WALKING: assert property (@(posedge clk) disable iff (!rst_n)
        pg_en |-> (state == ST_PROG)); // R8
    AST_BUSY_NO_BUF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_we); // R9
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_on && $past(rd_on)) |=> $stable(rdata)); // R10
endmodule

bind wbuf_cmd_if wbuf_cmd_if_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .cmd     (wdata[7:0]),
    .rdata   (rdata),
    .state   (state_q),
    .seq_err (seq_err_q),
    .pgm_err (pgm_err_q),
    .buf_we  (buf_we),
    .pg_en   (pg_en)
);

// File: tb/wbuf_cmd_if_test.sv
module wbuf_cmd_if_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 10;
    localparam int BAW   = 8;
    localparam int DEPTH = 1 << BAW;
    localparam int WORDS = 1 << AW;
    localparam int PW    = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wbuf_cmd_if #(.ADDR_W(AW), .BUF_AW(BAW), .DATA_W(16), .PROG_WAIT(PW)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] model [WORDS];
    logic [15:0] bdat  [DEPTH];
    bit          bval  [DEPTH];

    localparam logic [15:0] SR_OK   = 16'h0080;
    localparam logic [15:0] SR_ERR  = 16'h00B0;
    localparam logic [15:0] SR_BUSY = 16'h0000;

    function automatic logic [AW-1:0] mk(input int blk, input int off);
        return AW'(blk * DEPTH + off);
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [15:0] dv);
        addr = a; wdata = dv; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [15:0] v);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        v = rdata;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_ready(input string req);
        logic [15:0] v;
        v = SR_BUSY;
        for (int i = 0; i < 2000 && v[7] == 1'b0; i++) bus_read('0, v);
        check(req, v, SR_OK);
    endtask

    task automatic open_seq(input int blk, input logic [15:0] cnt);
        for (int i = 0; i < DEPTH; i++) bval[i] = 1'b0;
        bus_write(mk(blk, 0), 16'h00E8);
        bus_write(mk(blk, 0), cnt);
    endtask

    task automatic send_data(input int blk, input int off, input logic [15:0] dv);
        bus_write(mk(blk, off), dv);
        bdat[off] = dv;
        bval[off] = 1'b1;
    endtask

    task automatic commit_model(input int blk);
        for (int i = 0; i < DEPTH; i++)
            if (bval[i]) model[blk * DEPTH + i] = model[blk * DEPTH + i] & bdat[i];
    endtask

    task automatic probe(input string req, input int blk, input int off);
        logic [15:0] v;
        bus_read(mk(blk, off), v);
        check(req, v, model[blk * DEPTH + off]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] v, v2;
        int          blk, n, off;
        void'($urandom(32'd7041));
        for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: erased array and clean status after reset
        bus_read(mk(0, 5), v);   check("R1 array", v, 16'hFFFF);
        bus_read(mk(3, 255), v); check("R1 array", v, 16'hFFFF);
        bus_write('0, 16'h0070);
        bus_read('0, v);         check("R1 status", v, SR_OK);

        // R2, R3: count of 70h means 113 words
        bus_write(mk(1, 0), 16'h00E8);
        bus_read(mk(1, 0), v);   check("R2 status after setup", v, SR_OK);
        for (int i = 0; i < DEPTH; i++) bval[i] = 1'b0;
        bus_write(mk(1, 0), 16'h0070);
        for (int i = 0; i < 113; i++) send_data(1, i, 16'($urandom));
        bus_write(mk(1, 0), 16'h00D0);
        bus_read('0, v);         check("R3 count 70h taken as length, busy", v, SR_BUSY);
        wait_ready("R7 ready after programming");
        commit_model(1);
        bus_write('0, 16'h00FF);
        probe("R4 first slot", 1, 0);
        probe("R4 last slot", 1, 112);
        probe("R4 slot beyond count", 1, 113);

        // R5: data write outside the block aborts
        open_seq(2, 16'h0001);
        send_data(2, 3, 16'h0000);
        bus_write(mk(0, 4), 16'h1234);
        bus_read('0, v);         check("R5 data outside block", v, SR_ERR);
        bus_write('0, 16'h0050);
        bus_read('0, v);         check("R11 clear flags", v, SR_OK);
        bus_write('0, 16'h00FF);
        probe("R5 array untouched", 2, 3);
        probe("R11 back to array", 2, 4);

        // R5: confirm outside block aborts
        open_seq(2, 16'h0000);
        send_data(2, 9, 16'h0000);
        bus_write(mk(3, 0), 16'h00D0);
        bus_read('0, v);         check("R5 confirm outside block", v, SR_ERR);
        bus_write('0, 16'h0050);
        bus_write('0, 16'h00FF);
        probe("R5 array untouched", 2, 9);

        // R6: wrong confirm code
        open_seq(0, 16'h0000);
        send_data(0, 7, 16'h0000);
        bus_write(mk(0, 0), 16'h00AA);
        bus_read('0, v);         check("R6 bad confirm", v, SR_ERR);
        bus_write('0, 16'h0050);
        bus_read('0, v);         check("R11 clear flags", v, SR_OK);
        bus_write('0, 16'h00FF);
        probe("R6 array untouched", 0, 7);

        // R7, R9, R10: writes ignored and read held during busy
        open_seq(3, 16'h0001);
        send_data(3, 10, 16'hA5A5);
        send_data(3, 10, 16'h0F0F);
        bus_write(mk(3, 0), 16'h00D0);
        bus_write(mk(3, 10), 16'h00FF);
        addr = '0; ce_n = 1'b0; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        v = rdata;
        repeat (DEPTH + PW + 40) @(negedge clk);
        v2 = rdata;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        check("R7 busy status", v, SR_BUSY);
        check("R10 held read not refreshed", v2, SR_BUSY);
        bus_read('0, v);         check("R9 FFh ignored while busy", v, SR_OK);
        commit_model(3);
        bus_write('0, 16'h00FF);
        probe("R4 later write replaces earlier", 3, 10);

        // R8: full buffer then random sequences, AND programming
        open_seq(0, 16'h00FF);
        for (int i = 0; i < DEPTH; i++) send_data(0, i, 16'($urandom));
        bus_write(mk(0, 0), 16'h00D0);
        wait_ready("R7 full buffer");
        commit_model(0);
        bus_write('0, 16'h00FF);
        probe("R8 full buffer", 0, 0);
        probe("R8 full buffer", 0, 255);

        for (int t = 0; t < 20; t++) begin
            blk = int'($urandom % 4);
            n   = 1 + int'($urandom % 24);
            open_seq(blk, 16'(n - 1));
            for (int k = 0; k < n; k++) begin
                off = int'($urandom % DEPTH);
                send_data(blk, off, 16'($urandom));
            end
            bus_write(mk(blk, 0), 16'h00D0);
            wait_ready("R7 random sequence");
            commit_model(blk);
            bus_write('0, 16'h00FF);
            probe("R8 random sequence", blk, off);
            for (int k = 0; k < 4; k++) probe("R8 random probe", blk, int'($urandom % DEPTH));
        end

        finish_run();
    end
endmodule